// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit decides where an 8-bit core goes next when it executes a control-transfer instruction. Each request carries the branch kind, the current program counter, the signed 8-bit displacement, a 16-bit absolute address, the A and X register values, the carry and zero flags, the value of an already-fetched test bit, an 8-bit loop counter and the instruction length in bytes. The unit returns the next program counter, whether the transfer was taken, the counter after its decrement, and the number of instruction clocks the instruction costs. Operand fetch and the storage of the counter are outside this unit. The core writes `res_cnt` back only for the decrement kinds.

Requests enter on a valid/ready port and results leave on a valid/ready port through one output register. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. Its result is presented with `res_valid` high from the next edge onward. While `res_valid` is high and `res_ready` is low, the result stays frozen and `req_ready` is low, so no new request enters. When `res_ready` is high, a new request can be accepted in the same cycle that the old result is taken. The same relative adder serves every displacement form, because its base is the current PC plus the supplied instruction length.

Top module: `br_unit`

## Requirements
- R1: While reset (`rst_n` low) is applied and after it is released, `res_valid` is 0 and `req_ready` is 1 until a request is accepted.
- R2: An accepted request yields `res_valid`=1 one cycle later. While `res_valid`=1 and `res_ready`=0, all result fields hold their values, `req_ready` is 0 and a request offered at that time is not accepted.
- R3: Kind 0 (absolute jump) is always taken, with next PC = `req_addr` and 6 cycles.
- R4: Kind 1 (register jump) is always taken, with next PC = {`req_a`,`req_x`} (A is the high byte) and 6 cycles.
- R5: Kind 2 (relative jump) is always taken, with next PC = PC + length + sign-extended displacement mod 2^16 and 6 cycles.
- R6: Kinds 3, 4, 5 and 6 branch when carry=1, carry=0, zero=1 and zero=0 respectively, and each costs 6 cycles.
- R7: Kinds 7 and 9 branch when the test bit is 1, and kinds 8 and 10 branch when it is 0. Kinds 7 and 8 (long bit forms) cost 10 cycles. Kinds 9 and 10 (accumulator bit forms) cost 8 cycles.
- R8: Kinds 11 (register counter, 6 cycles) and 12 (memory counter, 8 cycles) return `res_cnt` = counter − 1 mod 256 and branch if that result is nonzero. A counter of 0 gives 0xFF and the branch is taken. A counter of 1 gives 0 and the branch is not taken.
- R9: A taken conditional kind gives next PC = PC + length + sign-extended displacement, and a not-taken one gives PC + length, both mod 2^16. For every kind except 11 and 12, `res_cnt` equals the request counter.
- R10: Kinds 13 to 15 are reserved. They are never taken, give next PC = PC + length and cost 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_kind | input | 4 | Branch kind code (0..15) |
| req_pc | input | 16 | PC of the branch instruction |
| req_disp | input | 8 | Signed displacement |
| req_addr | input | 16 | Absolute target |
| req_a | input | 8 | A register (target high byte) |
| req_x | input | 8 | X register (target low byte) |
| req_cy | input | 1 | Carry flag |
| req_z | input | 1 | Zero flag |
| req_bit | input | 1 | Value of the tested bit |
| req_cnt | input | 8 | Loop counter before decrement |
| req_len | input | 3 | Instruction length in bytes |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_pc | output | 16 | Next program counter |
| res_taken | output | 1 | Transfer taken |
| res_cnt | output | 8 | Counter after decrement |
| res_cycles | output | 4 | Instruction clock count |

## Verification
The sweep drives every kind against every flag and test-bit combination, with PCs near 0xFFFF and displacements of +127, −128 and −1. A design that drops the carry out of the PC adder, or that zero-extends the displacement, returns wrong targets at the wrap and on backward branches. Counter values 0, 1 and 2 catch a design that tests the counter before the decrement: it would fall through on 0 and branch on 1. A stall phase offers a second request while the output is blocked. A design that ignores back-pressure would overwrite the held result or lose one of the two requests.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int PC_W  = 16;
  localparam int D_W   = 8;
  localparam int CYC_W = 4;
  localparam int LEN_W = 3;

  typedef enum logic [3:0] {
    K_JABS   = 4'd0,
    K_JREG   = 4'd1,
    K_JREL   = 4'd2,
    K_CY_SET = 4'd3,
    K_CY_CLR = 4'd4,
    K_Z_SET  = 4'd5,
    K_Z_CLR  = 4'd6,
    K_BL_ONE = 4'd7,
    K_BL_ZER = 4'd8,
    K_BA_ONE = 4'd9,
    K_BA_ZER = 4'd10,
    K_DEC_R  = 4'd11,
    K_DEC_M  = 4'd12,
    K_RSV13  = 4'd13,
    K_RSV14  = 4'd14,
    K_RSV15  = 4'd15
  } br_kind_e;

  localparam logic [CYC_W-1:0] CYC_SHORT = CYC_W'(6);
  localparam logic [CYC_W-1:0] CYC_MID   = CYC_W'(8);
  localparam logic [CYC_W-1:0] CYC_LONG  = CYC_W'(10);
  localparam logic [CYC_W-1:0] CYC_RSV   = CYC_W'(2);
endpackage

// File: rtl/br_target.sv
module br_target
  import br_pkg::*;
#(
  parameter int PW = PC_W,
  parameter int DW = D_W,
  parameter int LW = LEN_W
) (
  input  logic [PW-1:0] pc,
  input  logic [DW-1:0] disp,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] cnt,
  output logic [PW-1:0] seq_pc,
  output logic [PW-1:0] rel_pc,
  output logic [DW-1:0] cnt_dec,
  output logic          dec_nz
);
  localparam int EXT = PW - DW;
  logic [PW-1:0] disp_ext;

  assign disp_ext = {{EXT{disp[DW-1]}}, disp};
  assign seq_pc   = pc + PW'(len);
  assign rel_pc   = seq_pc + disp_ext;
  assign cnt_dec  = cnt - DW'(1);
  assign dec_nz   = |cnt_dec;
endmodule

// File: rtl/br_decide.sv
module br_decide
  import br_pkg::*;
(
  input  logic [3:0]       kind,
  input  logic             cy,
  input  logic             z,
  input  logic             tbit,
  input  logic             dec_nz,
  output logic             taken,
  output logic             is_dec,
  output logic [CYC_W-1:0] cycles
);
  br_kind_e k;
  assign k = br_kind_e'(kind);

  always_comb begin
    taken  = 1'b0;
    is_dec = 1'b0;
    cycles = CYC_RSV;
    unique case (k)
      K_JABS, K_JREG, K_JREL: begin
        taken  = 1'b1;
        cycles = CYC_SHORT;
      end
      K_CY_SET: begin taken = cy;    cycles = CYC_SHORT; end
      K_CY_CLR: begin taken = !cy;   cycles = CYC_SHORT; end
      K_Z_SET:  begin taken = z;     cycles = CYC_SHORT; end
      K_Z_CLR:  begin taken = !z;    cycles = CYC_SHORT; end
      K_BL_ONE: begin taken = tbit;  cycles = CYC_LONG;  end
      K_BL_ZER: begin taken = !tbit; cycles = CYC_LONG;  end
      K_BA_ONE: begin taken = tbit;  cycles = CYC_MID;   end
      K_BA_ZER: begin taken = !tbit; cycles = CYC_MID;   end
      K_DEC_R: begin
        taken  = dec_nz;
        is_dec = 1'b1;
        cycles = CYC_SHORT;
      end
      K_DEC_M: begin
        taken  = dec_nz;
        is_dec = 1'b1;
        cycles = CYC_MID;
      end
      default: begin
        taken  = 1'b0;
        cycles = CYC_RSV;
      end
    endcase
  end
endmodule

// File: rtl/br_unit.sv
module br_unit
  import br_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_kind,
  input  logic [PC_W-1:0]  req_pc,
  input  logic [D_W-1:0]   req_disp,
  input  logic [PC_W-1:0]  req_addr,
  input  logic [D_W-1:0]   req_a,
  input  logic [D_W-1:0]   req_x,
  input  logic             req_cy,
  input  logic             req_z,
  input  logic             req_bit,
  input  logic [D_W-1:0]   req_cnt,
  input  logic [LEN_W-1:0] req_len,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [PC_W-1:0]  res_pc,
  output logic             res_taken,
  output logic [D_W-1:0]   res_cnt,
  output logic [CYC_W-1:0] res_cycles
);
  logic [PC_W-1:0]  seq_pc, rel_pc, nxt_pc;
  logic [D_W-1:0]   cnt_dec, nxt_cnt;
  logic             dec_nz, taken, is_dec, accept;
  logic [CYC_W-1:0] cycles;

  br_target #(.PW(PC_W), .DW(D_W), .LW(LEN_W)) u_tgt (
    .pc(req_pc), .disp(req_disp), .len(req_len), .cnt(req_cnt),
    .seq_pc(seq_pc), .rel_pc(rel_pc), .cnt_dec(cnt_dec), .dec_nz(dec_nz)
  );

  br_decide u_dec (
    .kind(req_kind), .cy(req_cy), .z(req_z), .tbit(req_bit),
    .dec_nz(dec_nz), .taken(taken), .is_dec(is_dec), .cycles(cycles)
  );

  always_comb begin
    if (req_kind == K_JABS)      nxt_pc = req_addr;
    else if (req_kind == K_JREG) nxt_pc = {req_a, req_x};
    else if (taken)              nxt_pc = rel_pc;
    else                         nxt_pc = seq_pc;
    nxt_cnt = is_dec ? cnt_dec : req_cnt;
  end

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_pc     <= '0;
      res_taken  <= 1'b0;
      res_cnt    <= '0;
      res_cycles <= '0;
    end else begin
      if (req_ready) res_valid <= req_valid;
      if (accept) begin
        res_pc     <= nxt_pc;
        res_taken  <= taken;
        res_cnt    <= nxt_cnt;
        res_cycles <= cycles;
      end
    end
  end
endmodule

// File: rtl/br_unit_chk.sv
module br_unit_chk
  import br_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [3:0]       req_kind,
  input logic [D_W-1:0]   req_cnt,
  input logic             res_valid,
  input logic             res_ready,
  input logic [PC_W-1:0]  res_pc,
  input logic             res_taken,
  input logic [D_W-1:0]   res_cnt,
  input logic [CYC_W-1:0] res_cycles
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !res_valid); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_pc) && $stable(res_taken)
      && $stable(res_cnt) && $stable(res_cycles)); // R2
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !req_ready); // R2
  AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_kind <= 4'd2 |=> res_valid && res_taken && res_cycles == 4'd6); // R3
  AST_BIT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_kind == 4'd7 || req_kind == 4'd8) |=> res_cycles == 4'd10); // R7
  AST_DEC_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_kind == 4'd11 || req_kind == 4'd12) && req_cnt == 8'd1
      |=> !res_taken && res_cnt == 8'd0); // R8
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_kind == 4'd11 || req_kind == 4'd12) && req_cnt == 8'd0
      |=> res_taken && res_cnt == 8'hFF); // R8
  AST_RSV_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_kind >= 4'd13 |=> !res_taken && res_cycles == 4'd2); // R10
endmodule

bind br_unit br_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .req_cnt(req_cnt), .res_valid(res_valid),
  .res_ready(res_ready), .res_pc(res_pc), .res_taken(res_taken),
  .res_cnt(res_cnt), .res_cycles(res_cycles)
);

// File: tb/sim_br_unit.sv
`timescale 1ns/1ps
module sim_br_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, res_ready = 1'b0;
  logic req_ready, res_valid, res_taken;
  logic [3:0] req_kind = '0;
  logic [15:0] req_pc = '0, req_addr = '0, res_pc;
  logic [7:0] req_disp = '0, req_a = '0, req_x = '0, req_cnt = '0, res_cnt;
  logic req_cy = 1'b0, req_z = 1'b0, req_bit = 1'b0;
  logic [2:0] req_len = '0;
  logic [3:0] res_cycles;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  br_unit u0 (.*);

  function automatic logic [2:0] len_of(input int k);
    case (k)
      0, 9, 10, 12: return 3'd3;
      2, 3, 4, 5, 6, 11: return 3'd2;
      7, 8: return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  // packed {pc, taken, cnt, cycles}
  function automatic logic [28:0] model(input int k, input logic [15:0] pc,
      input logic [7:0] d, input logic [15:0] ad, input logic [7:0] a, x,
      input logic cy, z, b, input logic [7:0] c, input logic [2:0] ln);
    logic [15:0] seq, rel, npc;
    logic [7:0] oc;
    logic t;
    int cyc;
    seq = 16'((32'(pc) + 32'(ln)) % 65536);
    rel = 16'((32'(seq) + 65536 + $signed({{24{d[7]}}, d})) % 65536);
    oc = c; t = 1'b0; cyc = 2;
    case (k)
      0, 1, 2: begin t = 1'b1; cyc = 6; end                 // R3 R4 R5
      3: begin t = cy;  cyc = 6; end                         // R6
      4: begin t = !cy; cyc = 6; end
      5: begin t = z;   cyc = 6; end
      6: begin t = !z;  cyc = 6; end
      7: begin t = b;   cyc = 10; end                        // R7
      8: begin t = !b;  cyc = 10; end
      9: begin t = b;   cyc = 8; end
      10: begin t = !b; cyc = 8; end
      11, 12: begin                                          // R8
        oc = 8'((int'(c) + 255) % 256);
        t = (oc != 0);
        cyc = (k == 11) ? 6 : 8;
      end
      default: begin t = 1'b0; cyc = 2; end                  // R10
    endcase
    if (k == 0) npc = ad;
    else if (k == 1) npc = {a, x};
    else npc = t ? rel : seq;                                // R9
    return {npc, t, oc, 4'(cyc)};
  endfunction

  task automatic chk(input string tag, input logic [28:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got pc=%h t=%b cnt=%h cyc=%0d exp pc=%h t=%b cnt=%h cyc=%0d",
        tag, act[28:13], act[12], act[11:4], act[3:0],
        exp[28:13], exp[12], exp[11:4], exp[3:0]);
    end
  endtask

  task automatic drive(input int k, input logic [15:0] pc, input logic [7:0] d,
      input logic [15:0] ad, input logic [7:0] a, x, input logic cy, z, b,
      input logic [7:0] c, input logic [2:0] ln);
    req_kind = 4'(k); req_pc = pc; req_disp = d; req_addr = ad;
    req_a = a; req_x = x; req_cy = cy; req_z = z; req_bit = b;
    req_cnt = c; req_len = ln;
  endtask

  function automatic string tag_of(input int k);
    case (k)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3, 4, 5, 6: return "R6/R9";
      7, 8, 9, 10: return "R7/R9";
      11, 12: return "R8";
      default: return "R10";
    endcase
  endfunction

  initial begin
    logic [15:0] pcs [4];
    logic [7:0] disps [5];
    logic [7:0] cnts [4];
    logic [28:0] ea, eb;
    pcs = '{16'h0000, 16'h1234, 16'h7FFF, 16'hFFFE};
    disps = '{8'h00, 8'h05, 8'h7F, 8'h80, 8'hFF};
    cnts = '{8'h00, 8'h01, 8'h02, 8'hFF};
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++; // R1
    if (res_valid !== 1'b0 || req_ready !== 1'b1) begin
      bad++;
      $display("FAIL R1: valid=%b ready=%b exp valid=0 ready=1", res_valid, req_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    total++; // R1
    if (res_valid !== 1'b0 || req_ready !== 1'b1) begin
      bad++;
      $display("FAIL R1: valid=%b ready=%b exp valid=0 ready=1", res_valid, req_ready);
    end
    res_ready = 1'b1;
    for (int k = 0; k < 16; k++)
      for (int f = 0; f < 8; f++)
        for (int p = 0; p < 4; p++)
          for (int di = 0; di < 5; di++)
            for (int ci = 0; ci < 4; ci++) begin
              logic [15:0] ad;
              ad = pcs[p] ^ 16'hA5C3 ^ 16'(di * 257);
              drive(k, pcs[p], disps[di], ad, 8'(p * 37 + 1), 8'(di * 51 + ci),
                    f[0], f[1], f[2], cnts[ci], len_of(k));
              req_valid = 1'b1;
              @(negedge clk);
              req_valid = 1'b0;
              ea = model(k, pcs[p], disps[di], ad, 8'(p * 37 + 1), 8'(di * 51 + ci),
                         f[0], f[1], f[2], cnts[ci], len_of(k));
              if (res_valid !== 1'b1) begin
                total++; bad++;
                $display("FAIL R2: res_valid=%b exp 1", res_valid);
              end
              chk(tag_of(k), {res_pc, res_taken, res_cnt, res_cycles}, ea);
            end
    @(negedge clk);
    // back-pressure: result A blocked, request B offered meanwhile (R2)
    res_ready = 1'b0;
    drive(2, 16'hFFF0, 8'h20, 16'h0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b0, 8'h10, 3'd2);
    ea = model(2, 16'hFFF0, 8'h20, 16'h0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b0, 8'h10, 3'd2);
    req_valid = 1'b1;
    @(negedge clk);
    drive(11, 16'h0100, 8'hF0, 16'h0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd2);
    eb = model(11, 16'h0100, 8'hF0, 16'h0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd2);
    for (int i = 0; i < 3; i++) begin
      total++;
      if (res_valid !== 1'b1 || req_ready !== 1'b0) begin
        bad++;
        $display("FAIL R2: valid=%b ready=%b exp valid=1 ready=0", res_valid, req_ready);
      end
      chk("R2 hold", {res_pc, res_taken, res_cnt, res_cycles}, ea);
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 next", {res_pc, res_taken, res_cnt, res_cycles}, eb);
    @(negedge clk);
    total++;
    if (res_valid !== 1'b0) begin
      bad++;
      $display("FAIL R2: res_valid=%b exp 0 after drain", res_valid);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule